// File: doc/BRIEF.md
# Last-Rank Power Predictor for Memory Ranks

This block decides which memory ranks are powered in front of a multi-rank memory controller. When an I/O operation begins (`io_start`), it guesses that the operation will use the rank that the previous I/O used. It then powers up only that one rank. Every other rank stays off. A rank power-up takes a fixed number of cycles, and a rank only serves accesses once it is fully up.

The real rank of a request is not sent with it. Each request names a buffer block, and a small table holds the rank in which each buffer block is placed. The block looks up that rank when the request arrives. If the guess was right, the request is granted as soon as the rank is up, which is at once when it is already on. If the guess was wrong, the block turns off the wrongly predicted rank in the same cycle and starts waking the real rank only then. The request therefore waits the whole power-up time. The request's rank becomes the prediction for the next I/O. Counters of correct and wrong predictions are brought out for observation.

Top module: `mru_rank_pwr`

## Requirements
- R1: After reset, all ranks are off and none is waking, `pred_rank` is 0, both counters are 0, and every table entry holds rank 0.
- R2: A pulse on `io_start` (with no new request in that cycle) starts power-up of the rank in `pred_rank` if it is off. No other rank is powered afterwards.
- R3: A rank whose power-up starts at clock edge t shows `rank_wake` high from edge t and `rank_on` high from edge t+WAKE_CYC. It stays on until it is turned off.
- R4: `req_grant` is high in exactly the cycles where `req_valid` is high and the rank resolved for `req_blk` is on. A request whose rank is already on is granted in the cycle it is presented.
- R5: A write with `place_en` stores `place_rank` as the rank of block `place_blk`. A request's rank (`req_rank`) is the stored entry of `req_blk`.
- R6: A request whose resolved rank equals `pred_rank` when it is first presented adds one to `hit_cnt`.
- R7: A request whose resolved rank differs from `pred_rank` adds one to `miss_cnt`. At the first edge of that request, the real rank starts waking and the wrongly predicted rank turns off, so the grant comes WAKE_CYC+1 cycles after the request is first presented.
- R8: At the first edge of every request, `pred_rank` takes that request's resolved rank.
- R9: At most one rank is powered (on or waking) at any time.
- R10: A request is counted exactly once, however many cycles it waits for its grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_start | input | 1 | One-cycle pulse: a new I/O begins, power the predicted rank |
| place_en | input | 1 | Write enable for the block-to-rank table |
| place_blk | input | BLK_W | Buffer block written |
| place_rank | input | RANK_W | Rank where that block is placed |
| req_valid | input | 1 | A request is present; held until granted |
| req_blk | input | BLK_W | Buffer block the request accesses |
| req_grant | output | 1 | Request may proceed; its rank is on |
| req_rank | output | RANK_W | Rank resolved for `req_blk` |
| pred_rank | output | RANK_W | Rank predicted for the next I/O |
| rank_on | output | NUM_RANKS | Per-rank: fully powered |
| rank_wake | output | NUM_RANKS | Per-rank: power-up in progress |
| hit_cnt | output | CNT_W | Count of correct predictions |
| miss_cnt | output | CNT_W | Count of wrong predictions |

## Verification
The properties assume that a requester holds `req_valid` and `req_blk` steady until it sees `req_grant`, and drops `req_valid` in the cycle that follows. They also assume that `io_start` never pulses in the same cycle in which a new request first appears, and that the table entry of a pending block is not rewritten. The bench drives these inputs from sequential tasks. Each task waits for its grant before the next begins, and table writes and `io_start` pulses happen only between requests. These rules therefore hold on every path the bench takes.

// File: rtl/mru_pwr_pkg.sv
// Shared types for the last-rank power predictor.
// Assumes nothing beyond a standard SystemVerilog package scope.
package mru_pwr_pkg;
    typedef enum logic [1:0] {
        PWR_OFF  = 2'd0,
        PWR_WAKE = 2'd1,
        PWR_ON   = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/rank_pwr_fsm.sv
// Power state machine for one rank: OFF -> WAKE (WAKE_CYC cycles) -> ON.
// sleep wins over wake; wake only acts while the rank is off.
// Assumes WAKE_CYC >= 1.
module rank_pwr_fsm
    import mru_pwr_pkg::*;
#(
    parameter int WAKE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic sleep,
    output logic is_on,
    output logic is_waking
);
    localparam int CNT_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;

    pwr_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;

    // State and power-up countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PWR_OFF;
            cnt_q <= '0;
        end else if (sleep) begin
            st_q  <= PWR_OFF;
            cnt_q <= '0;
        end else begin
            case (st_q)
                PWR_OFF: if (wake) begin
                    st_q  <= PWR_WAKE;
                    cnt_q <= CNT_W'(WAKE_CYC - 1);
                end
                PWR_WAKE: if (cnt_q == '0) st_q <= PWR_ON;
                          else             cnt_q <= cnt_q - 1'b1;
                default: st_q <= st_q;
            endcase
        end
    end

    // Decode state to status outputs.
    always_comb begin
        is_on     = (st_q == PWR_ON);
        is_waking = (st_q == PWR_WAKE);
    end
endmodule

// File: rtl/blk_rank_table.sv
// Block-to-rank table: one entry per buffer block holding its rank.
// One synchronous write port, one combinational read port. Reset clears to rank 0.
module blk_rank_table #(
    parameter int NUM_BLKS = 16,
    parameter int RANK_W   = 2,
    parameter int BLK_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic [RANK_W-1:0] wr_rank,
    input  logic [BLK_W-1:0]  rd_blk,
    output logic [RANK_W-1:0] rd_rank
);
    logic [RANK_W-1:0] tab_q [NUM_BLKS];

    // Entry storage with reset to rank 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BLKS; i++) tab_q[i] <= '0;
        end else if (wr_en) begin
            tab_q[wr_blk] <= wr_rank;
        end
    end

    // Lookup for the presented request.
    always_comb rd_rank = tab_q[rd_blk];
endmodule

// File: rtl/mru_rank_pwr.sv
// Last-rank power predictor. On io_start it powers the rank used by the
// previous I/O. When a request arrives, its rank is looked up and compared
// with the guess; non-target ranks are switched off and the real rank is woken.
// Assumes requests are held until granted and io_start never coincides with
// the first cycle of a request.
module mru_rank_pwr #(
    parameter int NUM_RANKS = 4,
    parameter int NUM_BLKS  = 16,
    parameter int WAKE_CYC  = 8,
    parameter int CNT_W     = 16,
    localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BLK_W    = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_start,
    input  logic                 place_en,
    input  logic [BLK_W-1:0]     place_blk,
    input  logic [RANK_W-1:0]    place_rank,
    input  logic                 req_valid,
    input  logic [BLK_W-1:0]     req_blk,
    output logic                 req_grant,
    output logic [RANK_W-1:0]    req_rank,
    output logic [RANK_W-1:0]    pred_rank,
    output logic [NUM_RANKS-1:0] rank_on,
    output logic [NUM_RANKS-1:0] rank_wake,
    output logic [CNT_W-1:0]     hit_cnt,
    output logic [CNT_W-1:0]     miss_cnt
);
    logic [RANK_W-1:0]    act_rank;
    logic [RANK_W-1:0]    pred_q;
    logic                 seen_q;
    logic                 first;
    logic                 hit;
    logic                 steer;
    logic [RANK_W-1:0]    target;
    logic [NUM_RANKS-1:0] wake_v;
    logic [NUM_RANKS-1:0] sleep_v;

    blk_rank_table #(
        .NUM_BLKS (NUM_BLKS),
        .RANK_W   (RANK_W),
        .BLK_W    (BLK_W)
    ) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (place_en),
        .wr_blk  (place_blk),
        .wr_rank (place_rank),
        .rd_blk  (req_blk),
        .rd_rank (act_rank)
    );

    // First cycle of a request and prediction outcome.
    always_comb begin
        first = req_valid && !seen_q;
        hit   = (act_rank == pred_q);
    end

    // Choose the one rank to keep powered and the ranks to switch off.
    always_comb begin
        steer  = 1'b0;
        target = pred_q;
        if (first) begin
            steer  = 1'b1;
            target = act_rank;
        end else if (io_start) begin
            steer  = 1'b1;
        end
        for (int r = 0; r < NUM_RANKS; r++) begin
            wake_v[r]  = steer && (RANK_W'(r) == target);
            sleep_v[r] = steer && (RANK_W'(r) != target);
        end
    end

    generate
        for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank
            rank_pwr_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .wake      (wake_v[g]),
                .sleep     (sleep_v[g]),
                .is_on     (rank_on[g]),
                .is_waking (rank_wake[g])
            );
        end
    endgenerate

    // Request tracking, prediction register and outcome counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            pred_q   <= '0;
            hit_cnt  <= '0;
            miss_cnt <= '0;
        end else begin
            seen_q <= req_valid && !req_grant;
            if (first) begin
                pred_q <= act_rank;
                if (hit) hit_cnt  <= hit_cnt + 1'b1;
                else     miss_cnt <= miss_cnt + 1'b1;
            end
        end
    end

    // Grant as soon as the resolved rank is on.
    always_comb begin
        req_grant = req_valid && rank_on[act_rank];
        req_rank  = act_rank;
        pred_rank = pred_q;
    end
endmodule

// File: rtl/mru_pwr_chk.sv
// Property checker for mru_rank_pwr, attached by bind.
// Assumes requests are held until granted and dropped the cycle after.
module mru_pwr_chk #(
    parameter int NUM_RANKS = 4,
    parameter int RANK_W    = 2,
    parameter int CNT_W     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 first,
    input logic                 hit,
    input logic                 req_grant,
    input logic [RANK_W-1:0]    req_rank,
    input logic [RANK_W-1:0]    pred_rank,
    input logic [NUM_RANKS-1:0] rank_on,
    input logic [NUM_RANKS-1:0] rank_wake,
    input logic [CNT_W-1:0]     hit_cnt,
    input logic [CNT_W-1:0]     miss_cnt
);
    p_one_powered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rank_on | rank_wake));

    p_grant_needs_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant |-> rank_on[req_rank]);

    p_on_after_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rank_on & ~$past(rank_on) & ~$past(rank_wake)) == '0);

    p_hit_counted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (first && hit) |=> hit_cnt == ($past(hit_cnt) + CNT_W'(1)));

    p_miss_wakes_real_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (first && !hit) |=> rank_wake[$past(req_rank)]);

    p_pred_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        first |=> pred_rank == $past(req_rank));

    p_count_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !first |=> ($stable(hit_cnt) && $stable(miss_cnt)));
endmodule

bind mru_rank_pwr mru_pwr_chk #(
    .NUM_RANKS (NUM_RANKS),
    .RANK_W    (RANK_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .first     (first),
    .hit       (hit),
    .req_grant (req_grant),
    .req_rank  (req_rank),
    .pred_rank (pred_rank),
    .rank_on   (rank_on),
    .rank_wake (rank_wake),
    .hit_cnt   (hit_cnt),
    .miss_cnt  (miss_cnt)
);

// File: tb/tb_mru_rank_pwr.sv
// Scoreboard bench: request tasks push the expected grant (cycle, rank) into a
// queue; a monitor pops and compares it when a grant appears.
module tb_mru_rank_pwr;
    localparam int NR = 4;
    localparam int NB = 16;
    localparam int W  = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_start = 1'b0;
    logic          place_en = 1'b0;
    logic [3:0]    place_blk = '0;
    logic [1:0]    place_rank = '0;
    logic          req_valid = 1'b0;
    logic [3:0]    req_blk = '0;
    logic          req_grant;
    logic [1:0]    req_rank;
    logic [1:0]    pred_rank;
    logic [NR-1:0] rank_on;
    logic [NR-1:0] rank_wake;
    logic [CW-1:0] hit_cnt;
    logic [CW-1:0] miss_cnt;

    mru_rank_pwr #(.NUM_RANKS(NR), .NUM_BLKS(NB), .WAKE_CYC(W), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .io_start(io_start),
        .place_en(place_en), .place_blk(place_blk), .place_rank(place_rank),
        .req_valid(req_valid), .req_blk(req_blk), .req_grant(req_grant),
        .req_rank(req_rank), .pred_rank(pred_rank), .rank_on(rank_on),
        .rank_wake(rank_wake), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_vec = 0;
    int n_bad = 0;
    int up_at [NR];
    int m_tab [NB];
    int m_pred = 0;
    int m_hit = 0;
    int m_miss = 0;
    int sb_cyc [$];
    int sb_rank [$];

    task automatic check(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Compare powered ranks, prediction and counters with the model.
    task automatic check_state(string tag);
        int exp_on;
        @(negedge clk);
        exp_on = 0;
        for (int r = 0; r < NR; r++)
            if (up_at[r] >= 0 && cyc >= up_at[r]) exp_on |= (1 << r);
        check({tag, " rank_on"}, int'(rank_on), exp_on);
        check({tag, " pred_rank R8"}, int'(pred_rank), m_pred);
        check({tag, " hit_cnt R6"}, int'(hit_cnt), m_hit);
        check({tag, " miss_cnt R7"}, int'(miss_cnt), m_miss);
        check({tag, " one powered R9"}, ($countones(rank_on | rank_wake) <= 1) ? 1 : 0, 1);
    endtask

    task automatic place(int blk, int rank);
        @(posedge clk); #1;
        place_en = 1'b1; place_blk = 4'(blk); place_rank = 2'(rank);
        m_tab[blk] = rank;
        @(posedge clk); #1;
        place_en = 1'b0;
    endtask

    task automatic io_pulse();
        int n;
        @(posedge clk); #1;
        io_start = 1'b1; n = cyc;
        for (int r = 0; r < NR; r++) begin
            if (r == m_pred) begin
                if (up_at[r] < 0) up_at[r] = n + 1 + W;
            end else begin
                up_at[r] = -1;
            end
        end
        @(posedge clk); #1;
        io_start = 1'b0;
    endtask

    // Present a request and push its expected grant to the scoreboard.
    task automatic request(int blk);
        int n, r, g;
        @(posedge clk); #1;
        req_valid = 1'b1; req_blk = 4'(blk); n = cyc;
        r = m_tab[blk];
        if (up_at[r] >= 0) g = (up_at[r] > n) ? up_at[r] : n;
        else               g = n + 1 + W;
        if (r == m_pred) m_hit++; else m_miss++;
        m_pred = r;
        for (int k = 0; k < NR; k++) if (k != r) up_at[k] = -1;
        if (up_at[r] < 0) up_at[r] = n + 1 + W;
        sb_cyc.push_back(g);
        sb_rank.push_back(r);
        wait (sb_cyc.size() == 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // Monitor: each grant must match the head of the scoreboard (R4, R5).
    always @(negedge clk) begin
        if (rst_n && req_grant) begin
            if (sb_cyc.size() == 0) begin
                check("R4 unexpected grant", 1, 0);
            end else begin
                check("R4 grant cycle", cyc, sb_cyc[0]);
                check("R5 grant rank", int'(req_rank), sb_rank[0]);
                void'(sb_cyc.pop_front());
                void'(sb_rank.pop_front());
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) up_at[r] = -1;
        for (int b = 0; b < NB; b++) m_tab[b] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_state("R1 reset");
        check("R1 no waking", int'(rank_wake), 0);

        place(1, 1);
        place(2, 2);
        place(15, 3);

        // R2/R3: predicted rank 0 wakes; request arrives while still waking.
        io_pulse();
        for (int i = 0; i < 3; i++) check_state("R3 waking");
        check("R2 rank0 waking", int'(rank_wake[0]), 1);
        request(0);                       // R6 hit, granted when up (R4)
        check_state("R6 after waiting hit");

        request(0);                       // R4 immediate grant on hit
        check_state("R10 immediate hit");

        request(2);                       // R7 miss: rank 0 off, rank 2 wakes
        check_state("R7 after miss");

        io_pulse();                       // R2: predicted rank 2 already on
        check_state("R2 second io");
        request(2);
        check_state("R6 hit rank2");

        io_pulse();
        request(15);                      // R5 table lookup -> rank 3, miss
        check_state("R7 miss to rank3");

        place(0, 3);                      // R5 rewrite entry
        io_pulse();
        request(0);                       // hit on rank 3, immediate
        check_state("R5 rewritten hit");

        request(1);                       // R7 miss to rank 1
        for (int i = 0; i < 2; i++) check_state("R9 idle");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule